// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one block-transfer request into a stream of single-word transfers. A request gives a byte base address, a 16-bit register-select mask, one of four addressing modes and a writeback enable. Once the request is accepted, the block emits one transfer per clock. Each transfer carries a word-aligned address and the index of the register that moves on that cycle. A one-cycle done pulse follows the last transfer. When writeback was requested, the updated base value comes out with that pulse.

Registers are always visited in ascending index order, and the addresses always ascend by one word. The mode decides only where the block sits relative to the base and what the new base is. The two increment modes place the block above the base. The two decrement modes first lower the start address and then still walk upward. A running sequence cannot be broken: further start requests are ignored while busy. An interrupt request that arrives during a sequence is held back and presented only once the sequence is done.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is held and after its release, before any start, busy_o, xfer_vld_o, done_o, wb_vld_o and irq_o are 0 and wb_base_o is 0.
- R2: A start sampled while busy_o is 0 is accepted. On the following N clocks (N = number of set mask bits), xfer_vld_o is 1 with xfer_reg_o stepping through the set bit indices in ascending order and xfer_addr_o rising by 4 each cycle. busy_o is 1 on exactly those N cycles.
- R3: mode_i = 2'b00 (increment, address then step): the first address is base and the new base is base + 4N.
- R4: mode_i = 2'b01 (step then increment): the first address is base + 4, and the new base is base + 4N, which equals the last address.
- R5: mode_i = 2'b10 (decrement, address then step): the first address is base − 4N + 4, the last address is base, and the new base is base − 4N.
- R6: mode_i = 2'b11 (step then decrement): the first address is base − 4N and the new base is base − 4N.
- R7: done_o is 1 for one cycle, on the clock after the last transfer, with busy_o and xfer_vld_o both 0. An empty mask gives done_o on the clock after the start, with no transfer.
- R8: wb_vld_o is 1 with done_o exactly when wb_en_i was 1 at the accepted start. wb_base_o then shows the new base. Otherwise wb_base_o keeps its previous value.
- R9: start_i asserted while busy_o is 1 is ignored. The running sequence keeps its addresses, registers and count.
- R10: xfer_addr_o bits [1:0] are always 0, even for an unaligned base. The new base is computed from the full base, low bits included. All address arithmetic wraps modulo 2^32.
- R11: irq_o is 0 whenever busy_o is 1. An irq_i seen during a sequence, including on its start edge, shows as irq_o = 1 in the done cycle. When idle, irq_o is irq_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a sequence (accepted when not busy) |
| base_i | input | 32 | Byte base address |
| mask_i | input | 16 | Register-select mask, bit i selects register i |
| mode_i | input | 2 | Addressing mode (see R3 to R6) |
| wb_en_i | input | 1 | Produce the updated base at the end |
| irq_i | input | 1 | Interrupt request input |
| busy_o | output | 1 | Sequence running |
| xfer_vld_o | output | 1 | A transfer is presented this cycle |
| xfer_addr_o | output | 32 | Word-aligned transfer address |
| xfer_reg_o | output | 4 | Register index of this transfer |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wb_vld_o | output | 1 | wb_base_o updated this cycle |
| wb_base_o | output | 32 | Updated base value |
| irq_o | output | 1 | Deferred interrupt request |

## Verification
The bench targets the following corner cases:

- **Unequal decrement base values.** Decrement modes are run with masks whose popcount makes the start address differ from the new base. A design that confuses the "after" and "before" offsets then shows a one-word shift on every address.
- **Empty mask.** A design that waits for a transfer would stall here, or emit a stray one.
- **Unaligned base.** A design that masks the base before adding would return a wrong new base.
- **Wrap below zero.** A design that does not wrap modulo 2^32 would give wrong addresses.
- **Start held high through a sequence.** This exposes a sequencer that reloads mid-run.
- **Interrupt pulse in mid-sequence.** This catches a design that leaks the interrupt early or loses it at done.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    MODE_INC_POST = 2'b00,
    MODE_INC_PRE  = 2'b01,
    MODE_DEC_POST = 2'b10,
    MODE_DEC_PRE  = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/blk_xfer_plan.sv
// Derives start address and final base from base, mask and mode.
module blk_xfer_plan
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NREG    = 16,
  parameter int ALIGN_B = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   mask_i,
  input  xfer_mode_e        mode_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] final_o
);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_B;

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(mask_i[i]);
  end

  assign span = ADDR_W'(cnt) << ALIGN_B;

  always_comb begin
    case (mode_i)
      MODE_INC_POST: begin start_o = base_i;               final_o = base_i + span; end
      MODE_INC_PRE:  begin start_o = base_i + STEP;        final_o = base_i + span; end
      MODE_DEC_POST: begin start_o = base_i - span + STEP; final_o = base_i - span; end
      default:       begin start_o = base_i - span;        final_o = base_i - span; end
    endcase
  end
endmodule

// File: rtl/blk_xfer_pick.sv
// Lowest-set-bit picker: index of the first selected register and the rest.
module blk_xfer_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  rest_o
);
  logic [NREG:0]   below;
  logic [NREG-1:0] first;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < NREG; g++) begin : g_scan
    assign below[g+1] = below[g] | mask_i[g];
    assign first[g]   = mask_i[g] & ~below[g];
  end

  assign any_o  = below[NREG];
  assign rest_o = mask_i & ~first;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NREG; i++)
      if (first[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/blk_xfer_irq_hold.sv
// Holds interrupt requests back while a sequence runs.
module blk_xfer_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic busy_nx_i,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else if (busy_nx_i) begin
      pend_q <= pend_q | irq_i;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      irq_o  <= pend_q | irq_i;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NREG    = 16,
  parameter int ALIGN_B = 2,
  parameter int IDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic [1:0]        mode_i,
  input  logic              wb_en_i,
  input  logic              irq_i,
  output logic              busy_o,
  output logic              xfer_vld_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [IDX_W-1:0]  xfer_reg_o,
  output logic              done_o,
  output logic              wb_vld_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1) << ALIGN_B;
  localparam logic [ADDR_W-1:0] ALIGN = ~((ADDR_W'(1) << ALIGN_B) - ADDR_W'(1));

  logic              accept, active, busy_nx;
  logic [NREG-1:0]   rem_q, sel_mask, pk_rest;
  logic              pk_any;
  logic [IDX_W-1:0]  pk_idx;
  logic [ADDR_W-1:0] next_q, final_q, sel_addr, plan_start, plan_final;
  logic              wb_en_q;

  assign accept   = start_i & ~busy_o;
  assign active   = accept | busy_o;
  assign sel_mask = accept ? mask_i : rem_q;
  assign sel_addr = accept ? plan_start : next_q;
  assign busy_nx  = active & pk_any;

  blk_xfer_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .ALIGN_B(ALIGN_B)) plan_i (
    .base_i (base_i),
    .mask_i (mask_i),
    .mode_i (xfer_mode_e'(mode_i)),
    .start_o(plan_start),
    .final_o(plan_final)
  );

  blk_xfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) pick_i (
    .mask_i(sel_mask),
    .any_o (pk_any),
    .idx_o (pk_idx),
    .rest_o(pk_rest)
  );

  blk_xfer_irq_hold irq_i_hold (
    .clk      (clk),
    .rst      (rst),
    .irq_i    (irq_i),
    .busy_nx_i(busy_nx),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o      <= 1'b0;
      xfer_vld_o  <= 1'b0;
      xfer_addr_o <= '0;
      xfer_reg_o  <= '0;
      done_o      <= 1'b0;
      wb_vld_o    <= 1'b0;
      wb_base_o   <= '0;
      rem_q       <= '0;
      next_q      <= '0;
      final_q     <= '0;
      wb_en_q     <= 1'b0;
    end else begin
      xfer_vld_o <= 1'b0;
      done_o     <= 1'b0;
      wb_vld_o   <= 1'b0;
      busy_o     <= busy_nx;
      if (accept) begin
        final_q <= plan_final;
        wb_en_q <= wb_en_i;
      end
      if (active) begin
        if (pk_any) begin
          xfer_vld_o  <= 1'b1;
          xfer_addr_o <= sel_addr & ALIGN;
          xfer_reg_o  <= pk_idx;
          rem_q       <= pk_rest;
          next_q      <= sel_addr + STEP;
        end else begin
          done_o <= 1'b1;
          if (accept ? wb_en_i : wb_en_q) begin
            wb_vld_o  <= 1'b1;
            wb_base_o <= accept ? plan_final : final_q;
          end
        end
      end
    end
  end

  // R10: transfer addresses are word aligned
  p_addr_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_vld_o |-> (xfer_addr_o & ~ALIGN) == '0);

  // R2: back-to-back transfers climb by one word and one register index at least
  p_ascending_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_vld_o && $past(xfer_vld_o)) |->
      (xfer_addr_o == $past(xfer_addr_o) + STEP && xfer_reg_o > $past(xfer_reg_o)));

  // R7: done never overlaps a transfer or busy
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!xfer_vld_o && !busy_o));

  // R8: the writeback strobe only comes with done
  p_wb_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    wb_vld_o |-> done_o);

  // R8: base output holds unless a writeback happens
  p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wb_vld_o |-> $stable(wb_base_o));

  // R11: interrupt stays hidden while a sequence runs
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !irq_o);
endmodule

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        irq_i = 1'b0;
  logic        busy_o, xfer_vld_o, done_o, wb_vld_o, irq_o;
  logic [31:0] xfer_addr_o, wb_base_o;
  logic [3:0]  xfer_reg_o;

  always #4 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
    .mode_i(mode_i), .wb_en_i(wb_en_i), .irq_i(irq_i), .busy_o(busy_o),
    .xfer_vld_o(xfer_vld_o), .xfer_addr_o(xfer_addr_o), .xfer_reg_o(xfer_reg_o),
    .done_o(done_o), .wb_vld_o(wb_vld_o), .wb_base_o(wb_base_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_ok = 0;
  bit          m_active = 0;
  bit          m_busy, m_vld, m_done, m_wbv, m_irq, m_pend, m_wben;
  bit [31:0]   m_addr, m_wbb, m_final;
  int          m_reg;
  int          m_mode;
  bit [31:0]   q_addr[$];
  int          q_reg[$];

  function automatic string mode_tag(int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_vld = 0; m_done = 0; m_wbv = 0; m_irq = 0; m_pend = 0;
      m_wbb = 0; m_active = 0; q_addr.delete(); q_reg.delete();
    end else begin
      if (start_i && !m_busy) begin
        int n;
        bit [31:0] a;
        n = $countones(mask_i);
        m_mode = int'(mode_i);
        m_wben = wb_en_i;
        case (mode_i)
          2'd0: begin a = base_i;               m_final = base_i + 32'(4*n); end
          2'd1: begin a = base_i + 4;           m_final = base_i + 32'(4*n); end
          2'd2: begin a = base_i - 32'(4*n) + 4; m_final = base_i - 32'(4*n); end
          default: begin a = base_i - 32'(4*n); m_final = base_i - 32'(4*n); end
        endcase
        for (int i = 0; i < 16; i++)
          if (mask_i[i]) begin
            q_addr.push_back({a[31:2], 2'b00});
            q_reg.push_back(i);
            a = a + 4;
          end
        m_active = 1;
      end
      m_vld = 0; m_done = 0; m_wbv = 0;
      if (m_active) begin
        if (q_addr.size() > 0) begin
          m_vld = 1; m_busy = 1;
          m_addr = q_addr.pop_front();
          m_reg = q_reg.pop_front();
        end else begin
          m_done = 1; m_busy = 0; m_active = 0;
          if (m_wben) begin m_wbv = 1; m_wbb = m_final; end
        end
      end
      if (m_busy) begin m_irq = 0; m_pend = m_pend | irq_i; end
      else begin m_irq = m_pend | irq_i; m_pend = 0; end
    end
    m_ok = 1;
  end

  // per-clock comparison, away from the active edge
  int vld_cnt = 0;
  bit prev_vld = 0;
  logic [31:0] first_addr = '0;
  always @(negedge clk) begin
    if (m_ok && !rst) begin
      chk("R2 busy_o", 32'(busy_o), 32'(m_busy));
      chk({mode_tag(m_mode), " xfer_vld_o"}, 32'(xfer_vld_o), 32'(m_vld));
      if (m_vld) begin
        chk({mode_tag(m_mode), " xfer_addr_o"}, xfer_addr_o, m_addr);
        chk("R2 xfer_reg_o", 32'(xfer_reg_o), 32'(m_reg));
      end
      chk("R7 done_o", 32'(done_o), 32'(m_done));
      chk("R8 wb_vld_o", 32'(wb_vld_o), 32'(m_wbv));
      chk("R8 wb_base_o", wb_base_o, m_wbb);
      chk("R11 irq_o", 32'(irq_o), 32'(m_irq));
    end
    if (xfer_vld_o === 1'b1) begin
      vld_cnt++;
      if (!prev_vld) first_addr = xfer_addr_o;
    end
    prev_vld = (xfer_vld_o === 1'b1);
  end

  task automatic do_op(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                       input logic wb, output int cnt);
    int c0;
    @(negedge clk);
    c0 = vld_cnt;
    base_i = b; mask_i = m; mode_i = md; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (done_o !== 1'b1) @(negedge clk);
    cnt = vld_cnt - c0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int cnt;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 busy_o", 32'(busy_o), 0);
    chk("R1 done_o", 32'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 xfer_vld_o", 32'(xfer_vld_o), 0);
    chk("R1 wb_vld_o", 32'(wb_vld_o), 0);
    chk("R1 wb_base_o", wb_base_o, 0);
    chk("R1 irq_o", 32'(irq_o), 0);

    // R3: three registers from 0x80010
    do_op(32'h80010, 16'h000E, 2'd0, 1'b1, cnt);
    chk("R3 count", 32'(cnt), 3);
    chk("R3 first addr", first_addr, 32'h80010);
    chk("R3 new base", wb_base_o, 32'h8001C);
    // R4
    do_op(32'h80010, 16'h000E, 2'd1, 1'b1, cnt);
    chk("R4 first addr", first_addr, 32'h80014);
    chk("R4 new base", wb_base_o, 32'h8001C);
    // R5
    do_op(32'h1000, 16'h0012, 2'd2, 1'b1, cnt);
    chk("R5 first addr", first_addr, 32'h0FFC);
    chk("R5 new base", wb_base_o, 32'h0FF8);
    // R6
    do_op(32'h1000, 16'h0012, 2'd3, 1'b1, cnt);
    chk("R6 first addr", first_addr, 32'h0FF8);
    chk("R6 new base", wb_base_o, 32'h0FF8);
    // R7: empty mask, no transfer, writeback of the unchanged base
    do_op(32'h2220, 16'h0000, 2'd3, 1'b1, cnt);
    chk("R7 empty count", 32'(cnt), 0);
    chk("R7 empty base", wb_base_o, 32'h2220);
    // R8: no writeback keeps the old base
    held = wb_base_o;
    do_op(32'h5000, 16'h00F0, 2'd0, 1'b0, cnt);
    chk("R8 wb_vld_o low", 32'(wb_vld_o), 0);
    chk("R8 base held", wb_base_o, held);
    // R10: unaligned base, and wrap below zero
    do_op(32'h1003, 16'h8001, 2'd0, 1'b1, cnt);
    chk("R10 aligned first", first_addr, 32'h1000);
    chk("R10 full base", wb_base_o, 32'h100B);
    do_op(32'h8, 16'h0007, 2'd3, 1'b1, cnt);
    chk("R10 wrap first", first_addr, 32'hFFFFFFFC);
    chk("R10 wrap base", wb_base_o, 32'hFFFFFFFC);

    // R9: start held high through a sequence with other parameters
    @(negedge clk);
    cnt = vld_cnt;
    base_i = 32'h3000; mask_i = 16'h0F00; mode_i = 2'd0; wb_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    base_i = 32'h9990; mask_i = 16'hFFFF; mode_i = 2'd3;
    while (busy_o === 1'b1) @(negedge clk);
    start_i = 1'b0;
    chk("R9 count unchanged", 32'(vld_cnt - cnt), 4);
    chk("R9 base unchanged", wb_base_o, 32'h3010);

    // R11: interrupt pulse in mid-sequence
    @(negedge clk);
    base_i = 32'h400; mask_i = 16'h00FF; mode_i = 2'd1; wb_en_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    irq_i = 1'b1;
    @(negedge clk);
    irq_i = 1'b0;
    chk("R11 hidden while busy", 32'(irq_o), 0);
    while (done_o !== 1'b1) @(negedge clk);
    chk("R11 shown at done", 32'(irq_o), 1);
    @(negedge clk);
    irq_i = 1'b1;
    @(negedge clk);
    irq_i = 1'b0;
    chk("R11 idle passthrough", 32'(irq_o), 1);

    // mixed stimulus, checked cycle by cycle by the model (R2..R8)
    for (int k = 0; k < 40; k++) begin
      logic [15:0] mm;
      mm = (k % 7 == 0) ? 16'h0 : 16'($urandom);
      irq_i = (k % 5 == 0);
      do_op($urandom, mm, 2'($urandom), 1'($urandom), cnt);
      chk("R2 count", 32'(cnt), 32'($countones(mm)));
    end
    irq_i = 1'b0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule